// File: doc/BRIEF.md
# Programmable-Oversampling Serial Bit-Timing Generator

This block produces the timing strobes for an asynchronous serial port whose oversampling ratio can be changed while the system runs. A byte-wide register port holds a 16-bit prescale divisor, a line-control byte, a speed-mode field, a samples-per-bit register and a capture-index register. From the system clock the block derives three strobes: a per-sample tick, a bit-boundary strobe and a capture strobe. A receiver and a transmitter built around the block use these strobes.

The divisor is loaded one byte at a time. The two divisor bytes share their addresses with the transmit-data port and the interrupt-enable byte, and bit 7 of the line-control byte selects which of the two sets a write reaches. The speed mode sets the number of samples that make up one bit. It also sets the sample index at which the bit value is taken. The receiver can raise an alignment request while it waits for a start bit. The next falling edge on the serial line then restarts the timing, so that the capture strobe falls near the centre of the start bit.

Top module: `uart_baud_sampler`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, all strobes, `tx_data_valid`, `line_ctrl` and `int_enable` are 0. After reset the divisor is 1 and the speed mode is 0, so a bit strobe appears every 16 cycles.
- R2: `sample_tick` is high for one cycle in every D cycles, where D is the divisor. A divisor of 0 behaves like a divisor of 1.
- R3: Address 3 writes the line-control byte, which is visible on `line_ctrl`. While `line_ctrl[7]` is 1, address 0 loads the low divisor byte and address 1 loads the high divisor byte.
- R4: While `line_ctrl[7]` is 0, a write to address 0 produces a one-cycle `tx_data_valid` pulse with the byte on `tx_data` in the cycle after the write edge. A write to address 1 sets `int_enable`. Neither write changes the divisor.
- R5: Speed mode 0 gives 16 samples per bit with capture index 7. The reserved mode 1 behaves exactly like mode 0.
- R6: Speed mode 2 gives 4 samples per bit with capture index 1.
- R7: In speed mode 3 the samples per bit equal the value at address 5 plus one, and the capture index is the value at address 6.
- R8: The speed mode is written through bits [1:0] at address 4.
- R9: A write to any timing register restarts the timing. These registers are the divisor bytes while the latch bit is set, and addresses 4, 5 and 6. With the write edge as cycle 0, the first capture strobe is at cycle (P+1)·D and the bit strobes are at cycles N·D, 2·N·D and so on, where N is the samples per bit and P is the capture index.
- R10: `bit_strobe` and `capture_strobe` are each high only in a cycle in which `sample_tick` is high.
- R11: While `align_en` is high, a falling edge on `rx_line` restarts the timing. Counting the first clock edge that sees the line low as edge 1, the restart happens at edge 3, and the capture strobe follows (P+1)·D cycles later.
- R12: While `align_en` is low, a falling edge on `rx_line` leaves the phase of the bit strobes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| rx_line | input | 1 | Serial receive line (asynchronous, idles high) |
| align_en | input | 1 | Receiver is hunting for a start bit |
| sample_tick | output | 1 | One-cycle pulse per oversampling sample |
| bit_strobe | output | 1 | One-cycle pulse at each bit boundary |
| capture_strobe | output | 1 | One-cycle pulse at the capture sample |
| line_ctrl | output | 8 | Line-control byte |
| int_enable | output | 8 | Interrupt-enable byte |
| tx_data_valid | output | 1 | Pulse when a transmit byte is written |
| tx_data | output | 8 | Last transmit byte written |

## Verification
A fault in the prescaler or in the sample counter shifts a strobe by whole multiples of D cycles. The bench measures each strobe against the cycle of the last timing write, so a shift shows up at the first capture strobe, which comes (P+1)·D cycles after the write. A divisor byte that reaches the wrong register, or is taken while the latch bit is clear, changes the bit period. A mode decoded wrongly moves the capture strobe within the bit. Each of these faults shows within one bit period of a restart. A fault in the start-edge synchroniser moves the restart by a few cycles, and the capture strobe that follows an alignment shows it directly.

// File: rtl/ubs_pkg.sv
package ubs_pkg;
  typedef enum logic [1:0] {
    SPD_X16  = 2'd0,
    SPD_RSVD = 2'd1,
    SPD_X4   = 2'd2,
    SPD_PROG = 2'd3
  } speed_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DLO = 3'd0;  // divisor low / tx data
  localparam logic [ADDR_W-1:0] A_DHI = 3'd1;  // divisor high / int enable
  localparam logic [ADDR_W-1:0] A_LCR = 3'd3;  // line control
  localparam logic [ADDR_W-1:0] A_SPD = 3'd4;  // speed mode
  localparam logic [ADDR_W-1:0] A_CNT = 3'd5;  // samples per bit minus one
  localparam logic [ADDR_W-1:0] A_PNT = 3'd6;  // capture index
  localparam int LATCH_BIT = 7;
endpackage

// File: rtl/ubs_regs.sv
module ubs_regs
  import ubs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int DIV_W   = 2 * DATA_W,
  parameter int RST_DIV = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIV_W-1:0]  div_raw,
  output logic [DIV_W-1:0]  div_eff,
  output speed_e            spd,
  output logic [CNT_W-1:0]  cnt_reg,
  output logic [CNT_W-1:0]  pnt_reg,
  output logic [DATA_W-1:0] lcr,
  output logic [DATA_W-1:0] ier,
  output logic              data_wr,
  output logic [DATA_W-1:0] data,
  output logic              resync
);
  logic latch;
  assign latch = lcr[LATCH_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr     <= '0;
      ier     <= '0;
      div_raw <= DIV_W'(RST_DIV);
      spd     <= SPD_X16;
      cnt_reg <= '0;
      pnt_reg <= '0;
      data_wr <= 1'b0;
      data    <= '0;
    end else begin
      data_wr <= 1'b0;
      if (wr) begin
        case (addr)
          A_DLO: begin
            if (latch) div_raw[DATA_W-1:0] <= wdata;
            else begin
              data_wr <= 1'b1;
              data    <= wdata;
            end
          end
          A_DHI: begin
            if (latch) div_raw[DIV_W-1:DATA_W] <= wdata[DIV_W-DATA_W-1:0];
            else       ier <= wdata;
          end
          A_LCR:   lcr     <= wdata;
          A_SPD:   spd     <= speed_e'(wdata[1:0]);
          A_CNT:   cnt_reg <= wdata[CNT_W-1:0];
          A_PNT:   pnt_reg <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    resync = 1'b0;
    if (wr) begin
      case (addr)
        A_DLO, A_DHI:        resync = latch;
        A_SPD, A_CNT, A_PNT: resync = 1'b1;
        default:             resync = 1'b0;
      endcase
    end
  end

  assign div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
endmodule

// File: rtl/ubs_prescaler.sv
module ubs_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_eff,
  output logic [DIV_W-1:0] presc,
  output logic             tick_en
);
  assign tick_en = (presc == div_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)   presc <= '0;
    else if (tick_en) presc <= '0;
    else              presc <= presc + DIV_W'(1);
  end
endmodule

// File: rtl/ubs_sample_ctr.sv
module ubs_sample_ctr
  import ubs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick_en,
  input  speed_e           spd,
  input  logic [CNT_W-1:0] cnt_reg,
  input  logic [CNT_W-1:0] pnt_reg,
  output logic [CNT_W-1:0] scnt,
  output logic             sample_tick,
  output logic             bit_strobe,
  output logic             capture_strobe
);
  localparam logic [CNT_W-1:0] X16_LAST = CNT_W'(15);
  localparam logic [CNT_W-1:0] X16_PNT  = CNT_W'(7);
  localparam logic [CNT_W-1:0] X4_LAST  = CNT_W'(3);
  localparam logic [CNT_W-1:0] X4_PNT   = CNT_W'(1);

  logic [CNT_W-1:0] last_idx, cap_idx;
  logic             at_last;

  always_comb begin
    case (spd)
      SPD_X4: begin
        last_idx = X4_LAST;
        cap_idx  = X4_PNT;
      end
      SPD_PROG: begin
        last_idx = cnt_reg;
        cap_idx  = pnt_reg;
      end
      default: begin
        last_idx = X16_LAST;
        cap_idx  = X16_PNT;
      end
    endcase
  end

  assign at_last = (scnt >= last_idx);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      scnt           <= '0;
      sample_tick    <= 1'b0;
      bit_strobe     <= 1'b0;
      capture_strobe <= 1'b0;
    end else begin
      sample_tick    <= tick_en;
      bit_strobe     <= tick_en && at_last;
      capture_strobe <= tick_en && (scnt == cap_idx);
      if (tick_en) scnt <= at_last ? '0 : scnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ubs_start_det.sv
module ubs_start_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_line,
  input  logic align_en,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= rx_line;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall = align_en && prev_q && !sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_baud_sampler.sv
module uart_baud_sampler
  import ubs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_DIV     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              rx_line,
  input  logic              align_en,
  output logic              sample_tick,
  output logic              bit_strobe,
  output logic              capture_strobe,
  output logic [DATA_W-1:0] line_ctrl,
  output logic [DATA_W-1:0] int_enable,
  output logic              tx_data_valid,
  output logic [DATA_W-1:0] tx_data
);
  localparam int DIV_W = 2 * DATA_W;

  logic [DIV_W-1:0] div_raw, div_eff, presc;
  speed_e           spd;
  logic [CNT_W-1:0] cnt_reg, pnt_reg, scnt;
  logic             resync, fall, clr, tick_en;

  assign clr = resync || fall;

  ubs_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .div_raw(div_raw), .div_eff(div_eff), .spd(spd), .cnt_reg(cnt_reg),
    .pnt_reg(pnt_reg), .lcr(line_ctrl), .ier(int_enable),
    .data_wr(tx_data_valid), .data(tx_data), .resync(resync)
  );

  ubs_start_det #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk(clk), .rst(rst), .rx_line(rx_line), .align_en(align_en), .fall(fall)
  );

  ubs_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .clr(clr), .div_eff(div_eff),
    .presc(presc), .tick_en(tick_en)
  );

  ubs_sample_ctr #(.CNT_W(CNT_W)) u_sctr (
    .clk(clk), .rst(rst), .clr(clr), .tick_en(tick_en), .spd(spd),
    .cnt_reg(cnt_reg), .pnt_reg(pnt_reg), .scnt(scnt),
    .sample_tick(sample_tick), .bit_strobe(bit_strobe),
    .capture_strobe(capture_strobe)
  );
endmodule

// File: rtl/uart_baud_sampler_chk.sv
module uart_baud_sampler_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] line_ctrl,
  input logic              sample_tick,
  input logic              bit_strobe,
  input logic              capture_strobe,
  input logic [DIV_W-1:0]  div_raw,
  input logic [DIV_W-1:0]  div_eff,
  input logic [DIV_W-1:0]  presc,
  input logic [CNT_W-1:0]  scnt,
  input logic              fall
);
  logic timing_wr;
  assign timing_wr = reg_wr && ((reg_addr >= 3'd4 && reg_addr <= 3'd6) ||
                     (reg_addr <= 3'd1 && line_ctrl[7]));

  a_r10_bit_on_tick: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> sample_tick);

  a_r10_cap_on_tick: assert property (@(posedge clk) disable iff (rst)
    capture_strobe |-> sample_tick);

  a_r4_latch_gate: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr <= 3'd1 && !line_ctrl[7]) |=> $stable(div_raw));

  a_r9_resync: assert property (@(posedge clk) disable iff (rst)
    timing_wr |=> (presc == '0 && scnt == '0));

  a_r11_align: assert property (@(posedge clk) disable iff (rst)
    fall |=> (presc == '0 && scnt == '0));

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (sample_tick && div_eff != DIV_W'(1)) |=> !sample_tick);
endmodule

bind uart_baud_sampler uart_baud_sampler_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(2*DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .line_ctrl(line_ctrl),
  .sample_tick(sample_tick), .bit_strobe(bit_strobe), .capture_strobe(capture_strobe),
  .div_raw(div_raw), .div_eff(div_eff), .presc(presc), .scnt(scnt), .fall(fall)
);

// File: tb/uart_baud_sampler_test.sv
module uart_baud_sampler_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       rx_line = 1'b1;
  logic       align_en = 1'b0;
  logic       sample_tick, bit_strobe, capture_strobe, tx_data_valid;
  logic [7:0] line_ctrl, int_enable, tx_data;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int c0 = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_baud_sampler uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_line(rx_line), .align_en(align_en), .sample_tick(sample_tick),
    .bit_strobe(bit_strobe), .capture_strobe(capture_strobe), .line_ctrl(line_ctrl),
    .int_enable(int_enable), .tx_data_valid(tx_data_valid), .tx_data(tx_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write one register; c0 = cycle count right after the write edge
  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    c0 = cyc;
  endtask

  // 0: sample_tick, 1: bit_strobe, 2: capture_strobe
  task automatic wait_ev(input int which, input int after, output int at);
    bit hit = 1'b0;
    at = -1;
    for (int n = 0; n < 4000 && !hit; n++) begin
      if (cyc > after && ((which == 0 && sample_tick) ||
                          (which == 1 && bit_strobe) ||
                          (which == 2 && capture_strobe))) begin
        at = cyc; hit = 1'b1;
      end else @(negedge clk);
    end
  endtask

  task automatic set_div(input int v);
    wr_reg(3'd3, 8'h83);
    wr_reg(3'd0, v[7:0]);
    wr_reg(3'd1, v[15:8]);
    wr_reg(3'd3, 8'h03);
  endtask

  task automatic t_reset;
    int a, b;
    @(negedge clk);
    chk("R1 strobes in reset", {29'd0, sample_tick, bit_strobe, capture_strobe}, 0);
    chk("R1 lcr in reset", line_ctrl, 0);
    chk("R1 ier in reset", int_enable, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobes after release", {30'd0, bit_strobe, tx_data_valid}, 0);
    wait_ev(1, cyc, a);
    wait_ev(1, a, b);
    chk("R1 default bit period", b - a, 16);
  endtask

  task automatic t_mode(input string req, input int div, input logic [1:0] m,
                        input int n, input int p);
    int a, b;
    set_div(div);
    wr_reg(3'd4, {6'd0, m});
    wait_ev(0, c0, a);
    chk({req, " first tick"}, a - c0, (div == 0) ? 1 : div);
    wait_ev(2, c0, a);
    chk({req, " capture offset"}, a - c0, (p + 1) * ((div == 0) ? 1 : div));
    wait_ev(1, c0, a);
    chk({req, " first bit strobe"}, a - c0, n * ((div == 0) ? 1 : div));
    wait_ev(1, a, b);
    chk({req, " bit period"}, b - a, n * ((div == 0) ? 1 : div));
  endtask

  task automatic t_prog;
    int a, b;
    set_div(2);
    wr_reg(3'd4, 8'h03);
    wr_reg(3'd5, 8'd9);
    wr_reg(3'd6, 8'd4);
    wait_ev(2, c0, a);
    chk("R7 capture offset", a - c0, 10);
    wait_ev(1, c0, a);
    chk("R7 first bit strobe", a - c0, 20);
    wait_ev(1, a, b);
    chk("R7 bit period", b - a, 20);
    chk("R3 lcr readback", line_ctrl, 8'h03);
  endtask

  task automatic t_latch;
    int a, b;
    set_div(3);
    wr_reg(3'd4, 8'h02);
    wr_reg(3'd0, 8'h5A);
    chk("R4 tx pulse", {31'd0, tx_data_valid}, 1);
    chk("R4 tx data", tx_data, 8'h5A);
    @(negedge clk);
    chk("R4 tx pulse one cycle", {31'd0, tx_data_valid}, 0);
    wr_reg(3'd1, 8'hA5);
    chk("R4 ier write", int_enable, 8'hA5);
    wr_reg(3'd4, 8'h02);
    wait_ev(1, c0, a);
    wait_ev(1, a, b);
    chk("R4 divisor unchanged", b - a, 12);
  endtask

  task automatic t_align;
    int f1, a;
    set_div(4);
    wr_reg(3'd4, 8'h00);
    repeat (13) @(negedge clk);
    align_en = 1'b1; rx_line = 1'b0;
    @(negedge clk);
    f1 = cyc;
    wait_ev(2, f1 + 2, a);
    chk("R11 capture after align", a - f1, 2 + 32);
    wait_ev(1, f1 + 2, a);
    chk("R11 bit after align", a - f1, 2 + 64);
    rx_line = 1'b1; align_en = 1'b0;
  endtask

  task automatic t_noalign;
    int a, b;
    set_div(2);
    wr_reg(3'd4, 8'h00);
    repeat (9) @(negedge clk);
    rx_line = 1'b0;
    repeat (6) @(negedge clk);
    rx_line = 1'b1;
    wait_ev(1, c0, a);
    chk("R12 phase kept", a - c0, 32);
    wait_ev(1, a, b);
    chk("R12 phase kept 2", b - c0, 64);
  endtask

  task automatic t_midresync;
    int a;
    set_div(5);
    wr_reg(3'd4, 8'h02);
    repeat (7) @(negedge clk);
    wr_reg(3'd4, 8'h02);
    wait_ev(2, c0, a);
    chk("R9 capture after rewrite", a - c0, 10);
    wait_ev(1, c0, a);
    chk("R9 bit after rewrite", a - c0, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mode("R5 mode0", 3, 2'd0, 16, 7);
    t_mode("R5 reserved mode1", 2, 2'd1, 16, 7);
    t_mode("R6 mode2", 5, 2'd2, 4, 1);
    t_mode("R2 divisor zero", 0, 2'd2, 4, 1);
    t_mode("R3 R8 wide divisor", 258, 2'd2, 4, 1);
    t_prog();
    t_latch();
    t_midresync();
    t_align();
    t_noalign();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule